// File: doc/BRIEF.md
# Source-Synchronous Receive Sample Deframer

The deframer sits behind the input deserializers of a source-synchronous transceiver receive port. Each user-clock cycle it takes one 8-bit parallel word from each data lane and one from the strobe lane. It keeps a short bit history per lane and uses the strobe to find where each I/Q sample begins. It then shifts the sample bits into place and presents a 16-bit I word and a 16-bit Q word with a one-cycle valid flag. The user clock runs faster than the sample rate, so valid is high on only one cycle out of every N, where N depends on the mode.

Three settings select the mode: the lane count (1, 2 or 4), SDR or DDR transfer, and 8- or 16-bit symbols. They are captured only while reset is asserted. Lock is gained when the strobe repeats at the expected period and bit position. Lock survives one missing strobe and is dropped after two consecutive misses.

Top module: `ssrx_deframer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_i` and `out_q` are zero whatever the lanes carry.
- R2: `cfg_lanes`, `cfg_sdr` and `cfg_sym8` are captured only on cycles where `rst` is high. Changing them while out of reset has no effect on the output.
- R3: In a word, bit 7 is the earliest bit on the wire. In DDR (`cfg_sdr`=0) all 8 bits are new each cycle. In SDR (`cfg_sdr`=1) only bits 7:4 carry data. With `cfg_lanes`=1 and 16-bit symbols, lane 0 carries I[15:0] then Q[15:0], MSB first, for 32 bits per sample.
- R4: With `cfg_lanes`=2, lane 0 carries I[15:0] and lane 1 carries Q[15:0], MSB first.
- R5: With `cfg_lanes`=4, lanes 0 to 3 carry I[15:8], I[7:0], Q[15:8] and Q[7:0] respectively, 8 bits each. A `cfg_lanes` value other than 2 or 4 selects one lane.
- R6: With one lane and `cfg_sym8`=1, lane 0 carries an 8-bit I then an 8-bit Q symbol. Each appears MSB-aligned in its output word with the low byte zero. `cfg_sym8` is ignored with 2 or 4 lanes.
- R7: Once locked, `out_valid` pulses once every N cycles. N = (bits per sample per lane) / (bits per lane per cycle), which gives 1, 2, 4 or 8.
- R8: A strobe bit may sit at any bit position of a strobe word. The sample is taken from the bits that start at the strobe, whatever their position relative to word boundaries.
- R9: A strobe bit marks the first bit of a sample. Sample k is output one cycle after the edge that samples the strobe word holding the start of sample k+1. `out_i` and `out_q` hold their values while `out_valid` is low.
- R10: The first strobe sets the reference. A second strobe exactly N cycles later at the same bit position gains lock and emits the sample between them. Lock is required for `out_valid`.
- R11: While locked, a missing strobe at the expected cycle suppresses that one sample and keeps lock. The next sample is emitted normally.
- R12: Two consecutive missed strobes drop lock. The next strobe only sets a new reference, and output resumes at the strobe after it.
- R13: While locked, strobe bits away from the expected cycle and position are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-side clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_lanes | input | 5 | Active lane count: 1, 2 or 4 |
| cfg_sdr | input | 1 | 1 = SDR, 0 = DDR |
| cfg_sym8 | input | 1 | 1 = 8-bit symbols, 0 = 16-bit symbols |
| lane_word | input | 32 | Lane l word at bits [8l+7:8l], bit 7 earliest |
| strobe_word | input | 8 | Strobe lane word, bit 7 earliest |
| out_valid | output | 1 | One-cycle pulse when a new sample pair is presented |
| out_i | output | 16 | I sample |
| out_q | output | 16 | Q sample |

## Verification
Every result appears exactly one cycle after the rising edge that samples the strobe word carrying the start of the following sample. The bench works out, for each driven word, whether that cycle must show a pulse and which I/Q pair. It compares `out_valid` and the data on the falling edge after each word is taken, so every cycle without a pulse is checked too. Cadence, bit offset and lock timing are covered this way in every mode, and in the scenarios with missing or stray strobes.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

  typedef enum logic [1:0] {
    LM_ONE  = 2'd0,
    LM_TWO  = 2'd1,
    LM_FOUR = 2'd2
  } lane_mode_e;

  typedef struct packed {
    lane_mode_e lm;
    logic       sdr;
    logic       sym8;
  } cfg_t;

  function automatic lane_mode_e decode_lanes(input logic [4:0] n);
    case (n)
      5'd2:    return LM_TWO;
      5'd4:    return LM_FOUR;
      default: return LM_ONE;
    endcase
  endfunction

  // log2 of bits per sample carried by one lane
  function automatic logic [2:0] len_shift(input cfg_t c);
    case (c.lm)
      LM_TWO:  return 3'd4;
      LM_FOUR: return 3'd3;
      default: return c.sym8 ? 3'd4 : 3'd5;
    endcase
  endfunction

  // log2 of user cycles per sample
  function automatic logic [1:0] ratio_shift(input cfg_t c);
    logic [2:0] d;
    d = len_shift(c) - (c.sdr ? 3'd2 : 3'd3);
    return d[1:0];
  endfunction

endpackage

// File: rtl/ssrx_lane_hist.sv
module ssrx_lane_hist #(
  parameter int WORD_W = 8,
  parameter int WIN_W  = 32,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              sdr,
  input  logic [OFF_W-1:0]  off,
  output logic [WIN_W-1:0]  window
);
  localparam int HIST_W = WIN_W + WORD_W;
  localparam int HALF_W = WORD_W / 2;

  logic [HIST_W-1:0] hist, nxt;

  always_comb begin
    if (sdr) nxt = {hist[HIST_W-HALF_W-1:0], word[WORD_W-1:HALF_W]};
    else     nxt = {hist[HIST_W-WORD_W-1:0], word};
    window = WIN_W'(nxt >> off);
  end

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= nxt;
  end
endmodule

// File: rtl/ssrx_strobe_lock.sv
module ssrx_strobe_lock #(
  parameter int WORD_W = 8,
  parameter int OFF_W  = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] stb,
  input  logic              sdr,
  input  logic [2:0]        ratio_m1,
  output logic              emit,
  output logic [OFF_W-1:0]  off,
  output logic              locked
);
  localparam int POS_W = $clog2(WORD_W);

  logic             have_ref, miss1, hit, expected, match;
  logic [POS_W-1:0] kref, k, ref_idx;
  logic [CNT_W-1:0] cnt;
  logic [OFF_W-1:0] nb;

  always_comb begin
    nb  = sdr ? OFF_W'(WORD_W / 2) : OFF_W'(WORD_W);
    hit = 1'b0;
    k   = '0;
    for (int j = WORD_W - 1; j >= 0; j--) begin
      if (j < int'(nb) && stb[WORD_W-1-j]) begin
        hit = 1'b1;
        k   = POS_W'(j);
      end
    end
    ref_idx  = POS_W'(WORD_W - 1) - kref;
    expected = (cnt == CNT_W'(ratio_m1));
    match    = expected && stb[ref_idx];
    emit     = locked ? match : (hit && have_ref && expected && (k == kref));
    off      = nb - OFF_W'(kref);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      have_ref <= 1'b0;
      miss1    <= 1'b0;
      kref     <= '0;
      cnt      <= '0;
    end else if (locked) begin
      cnt <= expected ? '0 : cnt + 1'b1;
      if (expected) begin
        if (match) miss1 <= 1'b0;
        else if (miss1) begin
          locked   <= 1'b0;
          have_ref <= 1'b0;
          miss1    <= 1'b0;
        end else miss1 <= 1'b1;
      end
    end else if (hit) begin
      kref     <= k;
      have_ref <= 1'b1;
      cnt      <= '0;
      if (have_ref && expected && (k == kref)) locked <= 1'b1;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssrx_deframer.sv
module ssrx_deframer
  import ssrx_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 8,
  parameter int SAMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4:0]              cfg_lanes,
  input  logic                    cfg_sdr,
  input  logic                    cfg_sym8,
  input  logic [LANES*WORD_W-1:0] lane_word,
  input  logic [WORD_W-1:0]       strobe_word,
  output logic                    out_valid,
  output logic [SAMP_W-1:0]       out_i,
  output logic [SAMP_W-1:0]       out_q
);
  localparam int WIN_W = 2 * SAMP_W;
  localparam int HALF  = SAMP_W / 2;
  localparam int OFF_W = $clog2(WORD_W) + 1;

  cfg_t              cfg_q;
  logic [2:0]        ratio_m1;
  logic              emit, is_locked, one_lane_sym8;
  logic [OFF_W-1:0]  off;
  logic [WIN_W-1:0]  win [LANES];
  logic [SAMP_W-1:0] nxt_i, nxt_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '{lm: decode_lanes(cfg_lanes), sdr: cfg_sdr, sym8: cfg_sym8};
  end

  always_comb begin
    ratio_m1      = 3'((4'd1 << ratio_shift(cfg_q)) - 4'd1);
    one_lane_sym8 = (cfg_q.lm == LM_ONE) && cfg_q.sym8;
  end

  ssrx_strobe_lock #(.WORD_W(WORD_W), .OFF_W(OFF_W), .CNT_W(4)) lock_i (
    .clk(clk), .rst(rst), .stb(strobe_word), .sdr(cfg_q.sdr),
    .ratio_m1(ratio_m1), .emit(emit), .off(off), .locked(is_locked)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ssrx_lane_hist #(.WORD_W(WORD_W), .WIN_W(WIN_W), .OFF_W(OFF_W)) hist_i (
      .clk(clk), .rst(rst), .word(lane_word[l*WORD_W +: WORD_W]),
      .sdr(cfg_q.sdr), .off(off), .window(win[l])
    );
  end

  always_comb begin
    case (cfg_q.lm)
      LM_TWO: begin
        nxt_i = win[0][SAMP_W-1:0];
        nxt_q = win[1][SAMP_W-1:0];
      end
      LM_FOUR: begin
        nxt_i = {win[0][HALF-1:0], win[1][HALF-1:0]};
        nxt_q = {win[2][HALF-1:0], win[3][HALF-1:0]};
      end
      default: begin
        if (cfg_q.sym8) begin
          nxt_i = {win[0][SAMP_W-1:HALF], {HALF{1'b0}}};
          nxt_q = {win[0][HALF-1:0], {HALF{1'b0}}};
        end else begin
          nxt_i = win[0][WIN_W-1:SAMP_W];
          nxt_q = win[0][SAMP_W-1:0];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_i <= nxt_i;
        out_q <= nxt_q;
      end
    end
  end
endmodule

// File: rtl/ssrx_deframer_chk.sv
module ssrx_deframer_chk #(
  parameter int SAMP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic [SAMP_W-1:0] out_i,
  input logic [SAMP_W-1:0] out_q,
  input logic [2:0]        ratio_m1,
  input logic              one_lane_sym8,
  input logic              is_locked
);
  localparam int HALF = SAMP_W / 2;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_i == '0 && out_q == '0));

  assert_msb_align_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && one_lane_sym8) |-> (out_i[HALF-1:0] == '0 && out_q[HALF-1:0] == '0));

  assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ratio_m1 != 3'd0) |=> !out_valid);

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

  assert_valid_needs_lock_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> is_locked);
endmodule

bind ssrx_deframer ssrx_deframer_chk #(.SAMP_W(SAMP_W)) chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
  .ratio_m1(ratio_m1), .one_lane_sym8(one_lane_sym8), .is_locked(is_locked)
);

// File: tb/ssrx_deframer_tb_top.sv
module ssrx_deframer_tb_top;
  localparam int NS   = 8;
  localparam int BITS = 512;
  localparam int CHK  = 136;

  typedef struct packed {
    logic [4:0] lanes;
    logic       sdr;
    logic       sym8;
    logic [2:0] lead;
    logic [1:0] tag;
  } vec_t;

  // lanes, sdr, sym8, lead bits, tag (0:R3 1:R6 2:R4 3:R5)
  localparam vec_t TABLE [8] = '{
    '{5'd1, 1'b0, 1'b0, 3'd0, 2'd0},
    '{5'd1, 1'b1, 1'b0, 3'd5, 2'd0},
    '{5'd1, 1'b0, 1'b1, 3'd3, 2'd1},
    '{5'd1, 1'b1, 1'b1, 3'd1, 2'd1},
    '{5'd2, 1'b0, 1'b0, 3'd6, 2'd2},
    '{5'd2, 1'b1, 1'b0, 3'd2, 2'd2},
    '{5'd4, 1'b0, 1'b0, 3'd7, 2'd3},
    '{5'd4, 1'b1, 1'b0, 3'd3, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  cfg_lanes;
  logic        cfg_sdr, cfg_sym8;
  logic [31:0] lane_word;
  logic [7:0]  strobe_word;
  logic        out_valid;
  logic [15:0] out_i, out_q;

  always #5 clk = ~clk;

  ssrx_deframer dut_i (
    .clk(clk), .rst(rst), .cfg_lanes(cfg_lanes), .cfg_sdr(cfg_sdr),
    .cfg_sym8(cfg_sym8), .lane_word(lane_word), .strobe_word(strobe_word),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic        lb [4][BITS];
  logic        sb [BITS];
  logic        ev [CHK];
  logic [15:0] ei [CHK];
  logic [15:0] eq [CHK];

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp,
                       input logic data_too);
    logic ok;
    ok = data_too ? (act == exp) : (act[32] == exp[32]);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic emitted(input int scen, input int s);
    if (scen == 1) return s != 2;
    if (scen == 2) return !(s >= 2 && s <= 4);
    return 1'b1;
  endfunction

  // scen: 0 clean, 1 one missing strobe, 2 two missing strobes, 3 stray strobe
  task automatic run(input logic [4:0] lanes, input logic sdr, input logic sym8,
                     input int lead, input int scen, input string tag, input logic late);
    int b, len, nch;
    logic [31:0] v [4];
    logic [15:0] si, sq;
    b   = sdr ? 4 : 8;
    len = (lanes == 5'd4) ? 8 : (lanes == 5'd2) ? 16 : (sym8 ? 16 : 32);
    for (int p = 0; p < BITS; p++) begin
      sb[p] = 1'b0;
      for (int l = 0; l < 4; l++) lb[l][p] = 1'b0;
    end
    for (int c = 0; c < CHK; c++) begin
      ev[c] = 1'b0; ei[c] = '0; eq[c] = '0;
    end
    for (int s = 0; s <= NS; s++) begin
      int pos;
      si  = 16'($urandom);
      sq  = 16'($urandom);
      pos = lead + s * len;
      for (int l = 0; l < 4; l++) v[l] = '0;
      if (lanes == 5'd4) begin
        v[0] = {24'd0, si[15:8]}; v[1] = {24'd0, si[7:0]};
        v[2] = {24'd0, sq[15:8]}; v[3] = {24'd0, sq[7:0]};
      end else if (lanes == 5'd2) begin
        v[0] = {16'd0, si}; v[1] = {16'd0, sq};
      end else if (sym8) v[0] = {16'd0, si[15:8], sq[15:8]};
      else v[0] = {si, sq};
      for (int l = 0; l < 4; l++)
        for (int t = 0; t < len; t++) lb[l][pos + t] = v[l][len - 1 - t];
      if (!((scen == 1 || scen == 2) && s == 3) && !(scen == 2 && s == 4)) sb[pos] = 1'b1;
      if (s < NS && emitted(scen, s)) begin
        int ch;
        ch     = (lead + (s + 1) * len) / b;
        ev[ch] = 1'b1;
        ei[ch] = (lanes != 5'd2 && lanes != 5'd4 && sym8) ? {si[15:8], 8'h00} : si;
        eq[ch] = (lanes != 5'd2 && lanes != 5'd4 && sym8) ? {sq[15:8], 8'h00} : sq;
      end
    end
    if (scen == 3) sb[lead + 4 * len + len / 2] = 1'b1;
    nch = (lead + (NS + 1) * len) / b + 3;

    @(negedge clk);
    rst = 1'b1; cfg_lanes = lanes; cfg_sdr = sdr; cfg_sym8 = sym8;
    lane_word = '0; strobe_word = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    if (late) begin
      cfg_lanes = 5'd4; cfg_sdr = ~sdr; cfg_sym8 = ~sym8;
    end
    for (int c = 0; c <= nch; c++) begin
      if (c > 0)
        check(tag, {out_valid, out_i, out_q}, {ev[c-1], ei[c-1], eq[c-1]}, ev[c-1]);
      if (c < nch) begin
        lane_word = '0; strobe_word = '0;
        for (int j = 0; j < b; j++) begin
          strobe_word[7 - j] = sb[c * b + j];
          for (int l = 0; l < 4; l++) lane_word[l * 8 + 7 - j] = lb[l][c * b + j];
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (R1) run did not complete");
    summary();
  end

  initial begin
    string tags [4];
    tags[0] = "R3 R7 R8 R9";
    tags[1] = "R6 R7 R8 R9";
    tags[2] = "R4 R7 R8 R9";
    tags[3] = "R5 R7 R8 R9";
    rst = 1'b1; cfg_lanes = 5'd1; cfg_sdr = 1'b0; cfg_sym8 = 1'b0;
    lane_word = '0; strobe_word = '0;
    repeat (2) @(negedge clk);

    // R1: reset state with busy lanes
    lane_word = '1; strobe_word = '1;
    repeat (3) @(negedge clk);
    check("R1", {out_valid, out_i, out_q}, 33'd0, 1'b1);

    foreach (TABLE[n])
      run(TABLE[n].lanes, TABLE[n].sdr, TABLE[n].sym8, int'(TABLE[n].lead), 0,
          tags[TABLE[n].tag], 1'b0);

    // R1: reset after traffic clears the outputs
    @(negedge clk);
    rst = 1'b1; lane_word = '1; strobe_word = '1;
    repeat (3) @(negedge clk);
    check("R1", {out_valid, out_i, out_q}, 33'd0, 1'b1);

    // R2: settings changed after reset must be ignored
    run(5'd1, 1'b0, 1'b0, 2, 0, "R2", 1'b1);
    // R10 and R11: lock gain, then one missing strobe keeps lock
    run(5'd1, 1'b0, 1'b0, 4, 1, "R10 R11", 1'b0);
    // R12: two missing strobes drop lock, relock later
    run(5'd1, 1'b0, 1'b0, 1, 2, "R12", 1'b0);
    run(5'd2, 1'b1, 1'b0, 3, 2, "R12", 1'b0);
    // R13: stray strobe while locked
    run(5'd2, 1'b0, 1'b0, 5, 3, "R13", 1'b0);
    run(5'd1, 1'b1, 1'b0, 0, 3, "R13", 1'b0);
    summary();
  end
endmodule